// File: doc/BRIEF.md
# Fault-Tolerant Radix-2 Signed-Digit Adder

This block adds two N-digit radix-2 signed-digit operands. Each digit takes a value in {-1, 0, +1}. Transfers between digit positions only reach the next higher position, so no carry runs across the full width. A single physical array of adder slices does every pass. The array is N+2 slices wide, which leaves two guard digits, and it produces N+3 physical output digits. The caller sees N+1 result digits.

Each fault-free addition is checked by a parity predictor. The predicted parity is the parity of the operands' encoded bits combined with the parity of the internal transfers, and it is compared with the parity of the sum's encoded bits. When the two disagree, the sequencer recomputes the same addition with both operands shifted up by one digit and then by two digits, and shifts each result back down. A slice fault lands on a different logical digit in each of the three results. A bitwise majority therefore recovers that sum. The digit where the unshifted result disagrees with the majority names the faulty slice, and its index is kept until reset.

From then on, every addition runs in one of two degraded modes, picked per operation by an input.
- **Correction mode:** two shifted passes, with the digits taken from whichever pass is known to be clean at each position. The full N+1 digits are returned.
- **Reduced-range mode:** a single pass with the operands placed above the faulty slice. Fewer digits are valid, and the number of valid digits is reported.

A stuck-at value can be forced onto one encoded bit of one slice output through a set of test inputs.

Top module: `sd_fault_tolerant_adder`

## Requirements
- R1: Each digit is two bits {plus, minus}: 00 is 0, 10 is +1, 01 is -1. With no fault present, the result (N+1 digits, digit j at bits 2j+1:2j) has the exact value of a plus b, with err low and valid_digits equal to N+1.
- R2: in_ready is high only while idle, and it drops after an operand pair is taken. Once out_valid rises, it stays high with sum unchanged until out_ready is seen.
- R3: No result digit is ever the pair 11.
- R4: An operand digit of 11 raises err with that result, and it never starts fault localization (fault_found stays low).
- R5: A stuck bit that corrupts a normal-mode result raises err with that result, and the delivered sum still has the exact value of a plus b.
- R6: After such a detection, fault_found goes high and fault_slice gives the index of the faulty output digit. Both hold until reset.
- R7: When fault_found is high and deg_mode is 0, the result is exact over all N+1 digits and valid_digits is N+1.
- R8: When fault_found is high and deg_mode is 1, valid_digits is min(N+1, N+2-k) for located slice k. Digits at and above valid_digits are 00. The result is exact when no operand digit above position N-k is nonzero.
- R9: After reset, in_ready is high, and out_valid, err and fault_found are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block idle, operands taken on this edge |
| op_a | input | 2N | Operand a, two bits per digit |
| op_b | input | 2N | Operand b, two bits per digit |
| deg_mode | input | 1 | Degraded mode: 0 correction, 1 reduced range |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Result consumed |
| sum | output | 2(N+1) | Result digits |
| err | output | 1 | Parity mismatch or illegal operand digit on this result |
| fault_found | output | 1 | A faulty slice has been located |
| fault_slice | output | clog2(N+3) | Index of the located slice |
| valid_digits | output | clog2(N+2) | Count of meaningful low result digits |
| inj_en | input | 1 | Test hook: enable stuck-at forcing |
| inj_slice | input | clog2(N+3) | Test hook: physical output digit to force |
| inj_bit | input | 1 | Test hook: 1 forces the plus bit, 0 the minus bit |
| inj_val | input | 1 | Test hook: forced value |

## Verification
The assertions take for granted that the stuck-at hook is static between resets and touches one encoded bit of a digit at or below position N. The property that the slice index is held depends on exactly this. They also assume that operands given in reduced-range mode have no nonzero digit above position N-k, where k is the located slice. Otherwise the truncated upper digits would make the returned value differ from a plus b. The stimulus changes the hook only while reset is held, and it sizes every reduced-range operand to the window left above the located slice.

// File: rtl/sd_fault_tolerant_adder.sv
module sd_fault_tolerant_adder #(
  parameter int N = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [2*N-1:0]               op_a,
  input  logic [2*N-1:0]               op_b,
  input  logic                         deg_mode,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [2*(N+1)-1:0]           sum,
  output logic                         err,
  output logic                         fault_found,
  output logic [$clog2(N+3)-1:0]       fault_slice,
  output logic [$clog2(N+2)-1:0]       valid_digits,
  input  logic                         inj_en,
  input  logic [$clog2(N+3)-1:0]       inj_slice,
  input  logic                         inj_bit,
  input  logic                         inj_val
);
  localparam int W  = N + 2;
  localparam int OW = N + 3;
  localparam int RD = N + 1;
  localparam int RB = 2 * RD;
  localparam int IW = $clog2(OW);
  localparam int VW = $clog2(RD + 1);

  typedef enum logic [2:0] {S_IDLE, S_PASS0, S_LOC1, S_LOC2, S_M1A, S_M1B, S_M2, S_OUT} st_t;
  st_t state;

  logic [2*N-1:0] a_q, b_q;
  logic [RB-1:0]  r0_q, r1_q, sum_q, res, maj, m1;
  logic           err_q, found_q, ill, perr;
  logic [IW-1:0]  idx_q, loc_k;
  logic [VW-1:0]  vd_q, vd2;
  logic [IW:0]    sh;
  logic [2*W-1:0] xa, xb, xal, xbl;
  logic [2*W+1:0] tv;
  logic [2*OW-1:0] sp, sf;

  function automatic int dv(logic [1:0] d);
    return int'(d[1]) - int'(d[0]);
  endfunction

  function automatic logic [1:0] enc(int v);
    return (v > 0) ? 2'b10 : (v < 0) ? 2'b01 : 2'b00;
  endfunction

  assign in_ready     = (state == S_IDLE);
  assign out_valid    = (state == S_OUT);
  assign sum          = sum_q;
  assign err          = err_q;
  assign fault_found  = found_q;
  assign fault_slice  = idx_q;
  assign valid_digits = vd_q;

  always_comb begin
    case (state)
      S_LOC1, S_M1A: sh = (IW+1)'(1);
      S_LOC2, S_M1B: sh = (IW+1)'(2);
      S_M2:          sh = {1'b0, idx_q} + (IW+1)'(1);
      default:       sh = '0;
    endcase
  end

  assign xa  = {4'b0000, a_q} << (2 * sh);
  assign xb  = {4'b0000, b_q} << (2 * sh);
  assign xal = {xa[2*W-3:0], 2'b00};
  assign xbl = {xb[2*W-3:0], 2'b00};

  always_comb begin
    logic [1:0] t, w, tin;
    logic lp;
    int p;
    tin = 2'b00;
    tv  = '0;
    sp  = '0;
    for (int i = 0; i < W; i++) begin
      p  = dv(xa[2*i+:2]) + dv(xb[2*i+:2]);
      lp = (xal[2*i+:2] != 2'b01) && (xbl[2*i+:2] != 2'b01);
      case (p)
        2:       begin t = 2'b10; w = 2'b00; end
        1:       begin t = lp ? 2'b10 : 2'b00; w = lp ? 2'b01 : 2'b10; end
        0:       begin t = 2'b00; w = 2'b00; end
        -1:      begin t = lp ? 2'b00 : 2'b01; w = lp ? 2'b01 : 2'b10; end
        default: begin t = 2'b01; w = 2'b00; end
      endcase
      sp[2*i+:2]      = enc(dv(w) + dv(tin));
      tv[2*(i+1)+:2]  = t;
      tin             = t;
    end
    sp[2*W+:2] = tin;
  end

  always_comb begin
    sf = sp;
    if (inj_en && int'(inj_slice) < OW)
      sf[2*int'(inj_slice) + int'(inj_bit)] = inj_val;
  end

  assign perr = (^xa) ^ (^xb) ^ (^tv) ^ (^sf);
  assign ill  = |((((a_q >> 1) & a_q) | ((b_q >> 1) & b_q)) & {N{2'b01}});
  assign res  = RB'(sf >> (2 * sh));
  assign maj  = (r0_q & r1_q) | (r0_q & res) | (r1_q & res);

  always_comb begin
    loc_k = '0;
    for (int j = RD - 1; j >= 0; j--)
      if (r0_q[2*j+:2] != maj[2*j+:2]) loc_k = IW'(j);
    for (int j = 0; j < RD; j++)
      m1[2*j+:2] = (int'(idx_q) == j + 1) ? res[2*j+:2] : r1_q[2*j+:2];
    if (int'(idx_q) >= N + 2)   vd2 = '0;
    else if (idx_q == '0)       vd2 = VW'(RD);
    else                        vd2 = VW'(N + 2 - int'(idx_q));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      a_q     <= '0;
      b_q     <= '0;
      r0_q    <= '0;
      r1_q    <= '0;
      sum_q   <= '0;
      err_q   <= 1'b0;
      found_q <= 1'b0;
      idx_q   <= '0;
      vd_q    <= VW'(RD);
    end else begin
      case (state)
        S_IDLE: if (in_valid) begin
          a_q   <= op_a;
          b_q   <= op_b;
          state <= !found_q ? S_PASS0 : (deg_mode ? S_M2 : S_M1A);
        end
        S_PASS0: begin
          vd_q <= VW'(RD);
          if (ill) begin
            sum_q <= res; err_q <= 1'b1; state <= S_OUT;
          end else if (perr) begin
            r0_q <= res; err_q <= 1'b1; state <= S_LOC1;
          end else begin
            sum_q <= res; err_q <= 1'b0; state <= S_OUT;
          end
        end
        S_LOC1: begin r1_q <= res; state <= S_LOC2; end
        S_LOC2: begin
          sum_q   <= maj;
          found_q <= 1'b1;
          idx_q   <= loc_k;
          state   <= S_OUT;
        end
        S_M1A: begin r1_q <= res; state <= S_M1B; end
        S_M1B: begin
          sum_q <= m1; err_q <= ill; vd_q <= VW'(RD); state <= S_OUT;
        end
        S_M2: begin
          sum_q <= res; err_q <= ill; vd_q <= vd2; state <= S_OUT;
        end
        S_OUT: if (out_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_fault_tolerant_adder_chk.sv
module sd_fault_tolerant_adder_chk #(
  parameter int N = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [2*(N+1)-1:0]     sum,
  input logic                   fault_found,
  input logic [$clog2(N+3)-1:0] fault_slice,
  input logic [$clog2(N+2)-1:0] valid_digits
);
  logic sum_ill, hi_nz;

  always_comb begin
    sum_ill = 1'b0;
    hi_nz   = 1'b0;
    for (int j = 0; j < N + 1; j++) begin
      if (sum[2*j+:2] == 2'b11) sum_ill = 1'b1;
      if (j >= int'(valid_digits) && sum[2*j+:2] != 2'b00) hi_nz = 1'b1;
    end
  end

  // R2
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);
  // R2
  hold_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(sum));
  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);
  // R3
  legal_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !sum_ill);
  // R6
  slice_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_found |=> fault_found && $stable(fault_slice));
  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !hi_nz);
  // R1
  full_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !fault_found |-> int'(valid_digits) == N + 1);
endmodule

bind sd_fault_tolerant_adder sd_fault_tolerant_adder_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .sum(sum),
  .fault_found(fault_found), .fault_slice(fault_slice),
  .valid_digits(valid_digits)
);

// File: tb/sd_fault_tolerant_adder_test.sv
module sd_fault_tolerant_adder_test;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, deg_mode = 1'b0;
  logic [2*N-1:0] op_a = '0, op_b = '0;
  logic in_ready, out_valid, err, fault_found;
  logic [2*(N+1)-1:0] sum;
  logic [3:0] fault_slice, valid_digits;
  logic inj_en = 1'b0, inj_bit = 1'b0, inj_val = 1'b0;
  logic [3:0] inj_slice = '0;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  logic [2*(N+1)-1:0] got_sum;
  logic got_err;
  logic [3:0] got_vd;

  always #4 clk = ~clk;

  sd_fault_tolerant_adder #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .deg_mode(deg_mode), .out_valid(out_valid),
    .out_ready(out_ready), .sum(sum), .err(err), .fault_found(fault_found),
    .fault_slice(fault_slice), .valid_digits(valid_digits), .inj_en(inj_en),
    .inj_slice(inj_slice), .inj_bit(inj_bit), .inj_val(inj_val)
  );

  localparam logic [31:0] VEC [8] = '{
    {16'hAAAA, 16'hAAAA}, {16'h5555, 16'h5555}, {16'hAAAA, 16'h5555},
    {16'h9A61, 16'h2854}, {16'h0A0A, 16'hA0A0}, {16'h8001, 16'h0102},
    {16'h6969, 16'h4242}, {16'h0000, 16'h0000}
  };

  function automatic int sdval(logic [2*(N+1)-1:0] v);
    int r = 0;
    for (int j = 0; j < N + 1; j++)
      r += (int'(v[2*j+1]) - int'(v[2*j])) * (1 << j);
    return r;
  endfunction

  function automatic bit has_ill(logic [2*(N+1)-1:0] v);
    for (int j = 0; j < N + 1; j++) if (v[2*j+:2] == 2'b11) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic add(logic [2*N-1:0] a, logic [2*N-1:0] b, logic m, int hold);
    @(negedge clk);
    op_a = a; op_b = b; deg_mode = m; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(!in_ready, "R2 busy after take", int'(in_ready), 0);
    while (!out_valid) @(negedge clk);
    got_sum = sum; got_err = err; got_vd = valid_digits;
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk(out_valid && sum == got_sum && !in_ready, "R2 result held",
          int'(out_valid), 1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic restart(logic en, logic [3:0] sl, logic bt, logic vl);
    @(negedge clk);
    rst_n = 1'b0;
    inj_en = en; inj_slice = sl; inj_bit = bt; inj_val = vl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_sum(string req, logic [2*N-1:0] a, logic [2*N-1:0] b);
    int e = sdval({2'b00, a}) + sdval({2'b00, b});
    chk(sdval(got_sum) == e, req, sdval(got_sum), e);
    chk(!has_ill(got_sum), "R3 legal digits", int'(has_ill(got_sum)), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    restart(1'b0, 4'd0, 1'b0, 1'b0);
    // R9 reset state
    chk(in_ready && !out_valid && !err && !fault_found, "R9 reset state",
        {in_ready, out_valid, err, fault_found}, 4'b1000);

    // R1 fault-free table
    for (int i = 0; i < 8; i++) begin
      add(VEC[i][31:16], VEC[i][15:0], 1'b0, 0);
      check_sum("R1 exact sum", VEC[i][31:16], VEC[i][15:0]);
      chk(!got_err && int'(got_vd) == N + 1, "R1 no err full width",
          {got_err, got_vd}, N + 1);
    end

    // R2 hold while out_ready low
    add(16'h9A61, 16'hAAAA, 1'b0, 3);
    check_sum("R1 exact sum after hold", 16'h9A61, 16'hAAAA);

    // R4 illegal operand digit (11 at digit 1)
    add(16'h000C, 16'h0000, 1'b0, 0);
    chk(got_err == 1'b1, "R4 illegal flags err", int'(got_err), 1);
    chk(!fault_found, "R4 no localization", int'(fault_found), 0);

    // fault on slice 3, plus bit stuck at 1
    restart(1'b1, 4'd3, 1'b1, 1'b1);
    add(16'h0000, 16'h0000, 1'b0, 0);
    chk(got_err == 1'b1, "R5 parity detects", int'(got_err), 1);
    check_sum("R5 corrected sum", 16'h0000, 16'h0000);
    chk(fault_found && fault_slice == 4'd3, "R6 located slice", int'(fault_slice), 3);
    for (int i = 0; i < 7; i++) begin
      add(VEC[i][31:16], VEC[i][15:0], 1'b0, 0);
      check_sum("R7 correction mode sum", VEC[i][31:16], VEC[i][15:0]);
      chk(int'(got_vd) == N + 1, "R7 full width", int'(got_vd), N + 1);
    end
    add(16'h0AAA, 16'h0AAA, 1'b1, 0);
    check_sum("R8 reduced range sum", 16'h0AAA, 16'h0AAA);
    chk(got_vd == 4'd7, "R8 valid digits k=3", int'(got_vd), 7);
    chk(got_sum[17:14] == 4'd0, "R8 upper digits zero", int'(got_sum[17:14]), 0);
    add(16'h0555, 16'h0A80, 1'b1, 0);
    check_sum("R8 reduced range mixed", 16'h0555, 16'h0A80);
    chk(fault_found && fault_slice == 4'd3, "R6 index held", int'(fault_slice), 3);

    // fault on slice 0, minus bit stuck at 1
    restart(1'b1, 4'd0, 1'b0, 1'b1);
    chk(!fault_found, "R9 reset clears located", int'(fault_found), 0);
    add(16'h0000, 16'h0000, 1'b0, 0);
    chk(got_err && fault_found && fault_slice == 4'd0, "R6 located slice 0",
        int'(fault_slice), 0);
    check_sum("R5 corrected sum slice 0", 16'h0000, 16'h0000);
    add(16'h9A61, 16'h2854, 1'b0, 0);
    check_sum("R7 correction slice 0", 16'h9A61, 16'h2854);
    add(16'hAAAA, 16'hAAAA, 1'b1, 0);
    check_sum("R8 reduced range slice 0", 16'hAAAA, 16'hAAAA);
    chk(int'(got_vd) == N + 1, "R8 valid digits k=0", int'(got_vd), N + 1);

    // fault on top result slice 8, plus bit stuck at 1
    restart(1'b1, 4'd8, 1'b1, 1'b1);
    add(16'h0000, 16'h0000, 1'b0, 0);
    chk(fault_found && fault_slice == 4'd8, "R6 located slice 8", int'(fault_slice), 8);
    add(16'hAAAA, 16'hAAAA, 1'b0, 0);
    check_sum("R7 correction slice 8", 16'hAAAA, 16'hAAAA);
    add(16'h0002, 16'h0002, 1'b1, 0);
    check_sum("R8 reduced range slice 8", 16'h0002, 16'h0002);
    chk(got_vd == 4'd2 && got_sum[17:4] == '0, "R8 two digits k=8", int'(got_vd), 2);

    // fault on slice 5, minus bit stuck at 0 (digit 5 of 0+32 is -1)
    restart(1'b1, 4'd5, 1'b0, 1'b0);
    add(16'h0000, 16'h0800, 1'b0, 0);
    chk(got_err == 1'b1, "R5 stuck-at-0 detected", int'(got_err), 1);
    check_sum("R5 stuck-at-0 corrected", 16'h0000, 16'h0800);
    chk(fault_found && fault_slice == 4'd5, "R6 located slice 5", int'(fault_slice), 5);
    add(16'h6969, 16'h4242, 1'b0, 0);
    check_sum("R7 correction slice 5", 16'h6969, 16'h4242);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule